// File: doc/BRIEF.md
# MIDI Note Message Decoder

This block sits behind a serial byte receiver. Each cycle it may be offered one received byte, with a valid strobe. It assembles those bytes into MIDI channel messages. Each byte is classified by its top bit. A status byte opens a message and names its type and channel. Data bytes fill in the message body. The block keeps the last channel status so that running-status streams decode correctly. It also knows which message types carry one data byte and which carry two.

When a Note On message completes with a nonzero velocity, the note number is latched onto a 7-bit output that drives a row of seven LEDs. In the same cycle, the velocity and channel of that note are latched onto their own outputs, and a single-cycle strobe marks the update. Every other message is framed and then skipped, so that it does not upset the byte count. This covers Note Off, Note On with zero velocity, controllers, program change and pitch bend. System bytes are skipped as well.

Top module: `midi_note_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `led_note`, `note_velocity` and `note_channel` are 0 and `note_strobe` is 0.
- R2: A byte offered with `rx_valid` high is a status byte when bit 7 is 1 and a data byte when bit 7 is 0. For a status byte, bits 7..4 give the message type: 0x9 is Note On and 0x8 is Note Off. Bits 3..0 give the channel.
- R3: When the second data byte of a Note On message is accepted at a clock edge and that byte is nonzero, `led_note` takes the first data byte (the note number) at that edge. `note_strobe` is high for exactly the following cycle. Two strobes are never adjacent.
- R4: `note_velocity` and `note_channel` take the second data byte and the status channel at the same edge as `led_note`. All three outputs hold their values whenever `note_strobe` is low.
- R5: A Note On whose second data byte is 0 leaves all outputs unchanged and gives no strobe.
- R6: Messages of other types (status 0x8, 0xA, 0xB, 0xC, 0xD, 0xE) are framed but change no output.
- R7: After a complete message, further data bytes reuse the last channel status (running status). For a Note On status this means alternating note and velocity bytes.
- R8: A status byte restarts framing even in the middle of a message. The next data byte is taken as the first data byte of the new message.
- R9: Data bytes are ignored when no channel status is in force. This holds after reset and after any status byte with upper nibble 0xF.
- R10: Status types 0xC and 0xD carry one data byte. Under running status, each further data byte is a complete message on its own. All other channel types carry two data bytes.
- R11: A byte offered with `rx_valid` low has no effect on framing or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte from the serial receiver |
| rx_valid | input | 1 | High for one cycle per received byte |
| led_note | output | 7 | Note number of the last accepted Note On, drives seven LEDs |
| note_strobe | output | 1 | One-cycle pulse when `led_note` is updated |
| note_velocity | output | 7 | Velocity of the last accepted Note On |
| note_channel | output | 4 | Channel of the last accepted Note On |

## Verification
The assertions assume that a byte is offered at most once per cycle. They also assume `rx_byte` is a known value whenever `rx_valid` is high. Under these assumptions, a Note On can complete at most every other cycle, which the no-adjacent-strobe property relies on. The stimulus offers bytes back to back and with idle gaps. It also offers a status byte on a cycle where `rx_valid` is low, to show that the valid strobe gates it. Every byte it sends is a defined value.

// File: rtl/midi_note_pkg.sv
package midi_note_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = BYTE_W - 1;
    localparam int CHAN_W = 4;
    localparam int TYPE_W = BYTE_W - CHAN_W;

    typedef enum logic [2:0] {
        K_NOTE_OFF,
        K_NOTE_ON,
        K_POLY_TOUCH,
        K_CONTROL,
        K_PROGRAM,
        K_CHAN_TOUCH,
        K_BEND
    } msg_kind_e;

    typedef struct packed {
        logic              live;
        msg_kind_e         kind;
        logic [CHAN_W-1:0] chan;
    } run_status_t;

    typedef struct packed {
        logic              take;
        logic              first;
        logic              last;
        msg_kind_e         kind;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] value;
    } data_evt_t;

    // Bits 6..4 of a channel status byte select the message type.
    function automatic msg_kind_e decode_kind(input logic [2:0] code);
        msg_kind_e k;
        case (code)
            3'd0:    k = K_NOTE_OFF;
            3'd1:    k = K_NOTE_ON;
            3'd2:    k = K_POLY_TOUCH;
            3'd3:    k = K_CONTROL;
            3'd4:    k = K_PROGRAM;
            3'd5:    k = K_CHAN_TOUCH;
            default: k = K_BEND;
        endcase
        return k;
    endfunction

    function automatic logic single_data(input msg_kind_e k);
        return (k == K_PROGRAM) || (k == K_CHAN_TOUCH);
    endfunction

endpackage

// File: rtl/midi_status_tracker.sv
module midi_status_tracker
    import midi_note_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output data_evt_t         evt
);

    localparam logic [TYPE_W-1:0] SYS_TYPE = '1;

    run_status_t cur;
    logic        second_due;
    logic        is_status;
    logic        is_data;

    assign is_status = byte_valid &  byte_in[BYTE_W-1];
    assign is_data   = byte_valid & ~byte_in[BYTE_W-1];

    always_comb begin
        evt.take  = is_data & cur.live;
        evt.first = ~second_due;
        evt.last  = second_due | single_data(cur.kind);
        evt.kind  = cur.kind;
        evt.chan  = cur.chan;
        evt.value = byte_in[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            second_due <= 1'b0;
        end else if (is_status) begin
            second_due <= 1'b0;
            if (byte_in[BYTE_W-1 -: TYPE_W] == SYS_TYPE) begin
                cur.live <= 1'b0;
            end else begin
                cur.live <= 1'b1;
                cur.kind <= decode_kind(byte_in[DATA_W-1 -: 3]);
                cur.chan <= byte_in[CHAN_W-1:0];
            end
        end else if (evt.take) begin
            second_due <= ~evt.last;
        end
    end

    // R8: a status byte always returns framing to the first data byte
    assert_status_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        is_status |=> !second_due);

    // R9: a pending second byte implies a channel status is in force
    assert_second_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
        second_due |-> cur.live);

    // R10: single-data-byte types never wait for a second byte
    assert_single_no_second_R10: assert property (@(posedge clk) disable iff (rst)
        (evt.take && single_data(cur.kind)) |=> !second_due);

endmodule

// File: rtl/midi_note_capture.sv
module midi_note_capture
    import midi_note_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  data_evt_t         evt,
    output logic [DATA_W-1:0] led_note,
    output logic              note_strobe,
    output logic [DATA_W-1:0] note_velocity,
    output logic [CHAN_W-1:0] note_channel
);

    logic [DATA_W-1:0] pend_note;
    logic              on_byte;
    logic              commit;

    assign on_byte = evt.take && (evt.kind == K_NOTE_ON);
    assign commit  = on_byte && !evt.first && evt.last && (evt.value != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_note     <= '0;
            led_note      <= '0;
            note_strobe   <= 1'b0;
            note_velocity <= '0;
            note_channel  <= '0;
        end else begin
            note_strobe <= commit;
            if (on_byte && evt.first) begin
                pend_note <= evt.value;
            end
            if (commit) begin
                led_note      <= pend_note;
                note_velocity <= evt.value;
                note_channel  <= evt.chan;
            end
        end
    end

    // R3: the update strobe lasts one cycle
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        note_strobe |=> !note_strobe);

    // R4: outputs move only together with the strobe
    assert_outputs_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !note_strobe |-> $stable({led_note, note_velocity, note_channel}));

    // R5: a published note never carries zero velocity
    assert_velocity_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        note_strobe |-> (note_velocity != '0));

endmodule

// File: rtl/midi_note_decoder.sv
module midi_note_decoder
    import midi_note_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [DATA_W-1:0] led_note,
    output logic              note_strobe,
    output logic [DATA_W-1:0] note_velocity,
    output logic [CHAN_W-1:0] note_channel
);

    data_evt_t evt;

    midi_status_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (rx_valid),
        .byte_in    (rx_byte),
        .evt        (evt)
    );

    midi_note_capture u_capture (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .led_note      (led_note),
        .note_strobe   (note_strobe),
        .note_velocity (note_velocity),
        .note_channel  (note_channel)
    );

    // R11: an unstrobed byte cannot produce a note update
    assert_idle_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !note_strobe);

endmodule

// File: tb/test_midi_note_decoder.sv
module test_midi_note_decoder;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic [6:0] led_note;
    logic       note_strobe;
    logic [6:0] note_velocity;
    logic [3:0] note_channel;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int rs = -1;
    int got = 0;
    int first_b = 0;
    int e_led = 0, e_vel = 0, e_chan = 0, e_stb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    midi_note_decoder i_midi_note_decoder (
        .clk           (clk),
        .rst           (rst),
        .rx_byte       (rx_byte),
        .rx_valid      (rx_valid),
        .led_note      (led_note),
        .note_strobe   (note_strobe),
        .note_velocity (note_velocity),
        .note_channel  (note_channel)
    );

    task automatic compare();
        vectors++;
        if (led_note !== 7'(e_led) || note_strobe !== 1'(e_stb) ||
            note_velocity !== 7'(e_vel) || note_channel !== 4'(e_chan)) begin
            fails++;
            $display("FAIL %s: led=%h stb=%b vel=%h ch=%h, expected led=%h stb=%0d vel=%h ch=%h",
                     cur_req, led_note, note_strobe, note_velocity, note_channel,
                     e_led, e_stb, e_vel, e_chan);
        end
    endtask

    // Model reaction to one offered byte, as seen after the next edge.
    task automatic model(input int b, input bit v);
        int len;
        e_stb = 0;
        if (!v) return;
        if (b >= 128) begin
            rs  = (b >= 8'hF0) ? -1 : b;
            got = 0;
        end else if (rs >= 0) begin
            len = ((rs >> 4) == 'hC || (rs >> 4) == 'hD) ? 1 : 2;
            if (got == 0) first_b = b;
            got++;
            if (got == len) begin
                got = 0;
                if ((rs >> 4) == 9 && b != 0) begin
                    e_led = first_b; e_vel = b; e_chan = rs & 15; e_stb = 1;
                end
            end
        end
    endtask

    task automatic offer(input int b, input bit v);
        @(negedge clk);
        compare();
        rx_byte  = 8'(b);
        rx_valid = v;
        model(b, v);
    endtask

    task automatic send(input int b);
        offer(b, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) offer(8'h00, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_valid = 1'b0;
        rs = -1; got = 0; e_led = 0; e_vel = 0; e_chan = 0; e_stb = 0;
        @(negedge clk);
        compare();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        do_reset();
        idle(2);

        cur_req = "R2";   // status classification, Note On channel 3
        send(8'h93); send(8'h3C); send(8'h64);
        idle(2);

        cur_req = "R3";   // boundary notes, velocity 1, back to back
        send(8'h90); send(8'h00); send(8'h7F);
        send(8'h9F); send(8'h7F); send(8'h01);
        idle(1);

        cur_req = "R11";  // status byte with valid low must not take effect
        offer(8'h85, 1'b0); send(8'h45); idle(1); send(8'h20);
        idle(2);

        cur_req = "R7";   // running status, with gaps
        send(8'h30); send(8'h10); idle(1); send(8'h31); idle(2); send(8'h11);
        idle(1);

        cur_req = "R5";   // zero velocity Note On
        send(8'h99); send(8'h50); send(8'h00); send(8'h51); send(8'h00);
        idle(2);

        cur_req = "R6";   // Note Off, controller, bend, poly
        send(8'h85); send(8'h22); send(8'h40);
        send(8'hB0); send(8'h07); send(8'h7F);
        send(8'hE1); send(8'h00); send(8'h40);
        send(8'hA2); send(8'h30); send(8'h30);
        idle(2);

        cur_req = "R4";   // channel and velocity follow the note
        send(8'h9A); send(8'h2B); send(8'h33);
        idle(2);

        cur_req = "R8";   // restart in mid message
        send(8'h92); send(8'h11); send(8'h94); send(8'h12); send(8'h33);
        send(8'h13); send(8'hB5); send(8'h14); send(8'h15); send(8'h16);
        idle(2);

        cur_req = "R10";  // single data byte types under running status
        send(8'hC2); send(8'h05); send(8'h06); send(8'h07);
        send(8'h95); send(8'h21); send(8'h22);
        send(8'hD1); send(8'h40); send(8'h41);
        send(8'h96); send(8'h55); send(8'h66);
        idle(2);

        cur_req = "R9";   // data without status
        send(8'hF0); send(8'h55); send(8'h66); send(8'h77);
        send(8'h93); send(8'h40); send(8'hF8); send(8'h41); send(8'h42);
        idle(1);
        do_reset();
        send(8'h12); send(8'h34); send(8'h56);
        idle(3);

        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule